// File: doc/BRIEF.md
# Four-Phase Instruction Fetch Sequencer

This block paces a two-stage instruction pipeline. It splits the input clock into four phase strobes that take turns, one per clock, so that every instruction cycle lasts four clocks. It holds the program counter and drives the fetch address to program memory. It captures the returned word into a prefetch register at the close of the fourth phase. One cycle later it moves that word into the instruction register for the execute stage. While the execute stage works on one word, the next word is already being fetched, so the pipeline completes one instruction per cycle.

The execute stage gets a data-read strobe in the second phase and a data-write strobe in the fourth phase. Both strobes stay low while the instruction register holds a bubble. A taken branch and an interrupt request are both sampled at the close of the fourth phase. Either one throws away the word fetched in that cycle, which puts a no-operation bubble into the following cycle, and then fetches from the new address. For an interrupt the block also reports the address to return to, for use by an external stack. The fetch address wraps to the size of the memory that is physically present, which is 2K or 4K words as set by a parameter.

Top module: `fetch_seq`

## Requirements
- R1: `q_stb` is one-hot at all times. It reads 4'b0001 (Q1) while in reset and steps Q1, Q2, Q3, Q4 (bits 0 to 3) and back to Q1, one step per clock.
- R2: The fetch address changes only at the clock edge that ends Q1, and it advances by one from the previous cycle's address. The word on `fetch_data` at the edge that ends Q4 appears on `ir` from the edge that ends the next Q1, with `ex_bubble` low.
- R3: `dm_rd` is high exactly during Q2 and `dm_wr` exactly during Q4 of a cycle whose `ex_bubble` is 0. Both are 0 in a bubble cycle.
- R4: When `br_take` is high at the edge ending Q4 of a non-bubble cycle, the next cycle is a bubble (`ir` = 14'h0000, `ex_bubble` = 1), and its fetch address is `br_target`.
- R5: `br_take` is ignored in a cycle with `ex_bubble` = 1: the fetch sequence carries on from the current address.
- R6: All fetch addresses, branch targets included, are masked to the physical memory size: 11 bits (mask 0x7FF) when `MEM_4K` is 0, and 12 bits (mask 0xFFF) when it is 1. Incrementing past the top wraps to 0.
- R7: After reset the first fetch address is 0x0000, the first cycle is a bubble, and `irq_ack` is 0.
- R8: When `irq_req` is high at the edge ending Q4, the next fetch address is 0x0004 and the next cycle is a bubble. `irq_ack` is high for exactly the following Q1 clock. `ret_addr` then holds the address of the discarded prefetch.
- R9: When a taken branch (non-bubble cycle) and an interrupt request come at the same Q4, the interrupt wins, and `ret_addr` holds the masked branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_data | input | 14 | Program memory word at `fetch_addr` |
| br_take | input | 1 | Execute stage requests a taken branch |
| br_target | input | 13 | Branch destination address |
| irq_req | input | 1 | Interrupt request |
| q_stb | output | 4 | Phase strobes, bit 0 = Q1 to bit 3 = Q4 |
| fetch_addr | output | 13 | Program memory fetch address |
| ir | output | 14 | Instruction register to the execute stage |
| ex_bubble | output | 1 | Instruction register holds a bubble |
| dm_rd | output | 1 | Data memory read strobe |
| dm_wr | output | 1 | Data memory write strobe |
| irq_ack | output | 1 | Interrupt taken, one-clock pulse |
| ret_addr | output | 13 | Return address for an interrupt |

## Verification
The assertions assume that `br_take`, `br_target` and `irq_req` are only meaningful at the edge that ends Q4. They also assume that `fetch_data` has settled to the word at `fetch_addr` by that same edge. The bench's memory model is a combinational function of `fetch_addr`. The bench drives the control inputs on the falling edge inside Q4 and clears them on the falling edge inside the next Q1, so each request covers exactly one sampling edge. The stimulus covers these cases: a branch into a bubble cycle, targets that straddle the top of the 2K space, and an interrupt that coincides with a branch or with a bubble.

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter bit          MEM_4K  = 1'b0,
  parameter int          AW      = 13,
  parameter int          IW      = 14,
  parameter logic [13:0] NOP_WORD = 14'h0000,
  parameter logic [12:0] RST_VEC  = 13'h0000,
  parameter logic [12:0] IRQ_VEC  = 13'h0004
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] fetch_data,
  input  logic          br_take,
  input  logic [AW-1:0] br_target,
  input  logic          irq_req,
  output logic [3:0]    q_stb,
  output logic [AW-1:0] fetch_addr,
  output logic [IW-1:0] ir,
  output logic          ex_bubble,
  output logic          dm_rd,
  output logic          dm_wr,
  output logic          irq_ack,
  output logic [AW-1:0] ret_addr
);
  localparam int PHYS_AW = MEM_4K ? 12 : 11;
  localparam logic [AW-1:0] MASK = {{(AW-PHYS_AW){1'b0}}, {PHYS_AW{1'b1}}};

  logic [1:0]    ph;
  logic [AW-1:0] pc, fa, ret_q;
  logic [IW-1:0] pf, ir_q;
  logic          pf_nop, ir_nop, ack_q;

  wire q1     = (ph == 2'd0);
  wire q4     = (ph == 2'd3);
  wire br_eff = br_take & ~ir_nop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= 2'd0;
      pc     <= RST_VEC & MASK;
      fa     <= RST_VEC & MASK;
      pf     <= NOP_WORD;
      ir_q   <= NOP_WORD;
      pf_nop <= 1'b1;
      ir_nop <= 1'b1;
      ack_q  <= 1'b0;
      ret_q  <= '0;
    end else begin
      ph    <= ph + 2'd1;
      ack_q <= 1'b0;
      if (q1) begin
        fa     <= pc;
        pc     <= (pc + 1'b1) & MASK;
        ir_q   <= pf;
        ir_nop <= pf_nop;
      end
      if (q4) begin
        pf     <= fetch_data;
        pf_nop <= 1'b0;
        if (irq_req) begin
          pc     <= IRQ_VEC & MASK;
          pf_nop <= 1'b1;
          ack_q  <= 1'b1;
          ret_q  <= br_eff ? (br_target & MASK) : fa;
        end else if (br_eff) begin
          pc     <= br_target & MASK;
          pf_nop <= 1'b1;
        end
      end
    end
  end

  assign q_stb      = 4'b0001 << ph;
  assign fetch_addr = fa;
  assign ir         = ir_nop ? NOP_WORD : ir_q;
  assign ex_bubble  = ir_nop;
  assign dm_rd      = q_stb[1] & ~ir_nop;
  assign dm_wr      = q_stb[3] & ~ir_nop;
  assign irq_ack    = ack_q;
  assign ret_addr   = ret_q;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter bit MEM_4K = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  q_stb,
  input logic [12:0] fetch_addr,
  input logic        ex_bubble,
  input logic        dm_rd,
  input logic        dm_wr,
  input logic        irq_ack,
  input logic        irq_req,
  input logic        br_take
);
  localparam logic [12:0] MASK = MEM_4K ? 13'h0FFF : 13'h07FF;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q_stb) == 1);
  a_r1_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    q_stb[3] |=> q_stb == 4'b0001);
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    !q_stb[3] |=> q_stb == ($past(q_stb) << 1));
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !q_stb[0] |=> $stable(fetch_addr));
  a_r3_rd_window: assert property (@(posedge clk) disable iff (!rst_n)
    dm_rd |-> (q_stb[1] && !ex_bubble));
  a_r3_wr_window: assert property (@(posedge clk) disable iff (!rst_n)
    dm_wr |-> (q_stb[3] && !ex_bubble));
  a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stb[3] && br_take && !ex_bubble) |=> ##1 ex_bubble);
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr & ~MASK) == 13'h0000);
  a_r8_ack_phase: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> q_stb[0]);
  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (q_stb[3] && irq_req) |=> ##1 (fetch_addr == 13'h0004 && ex_bubble));
endmodule

bind fetch_seq fetch_seq_chk #(.MEM_4K(MEM_4K)) i_chk (
  .clk(clk), .rst_n(rst_n), .q_stb(q_stb), .fetch_addr(fetch_addr),
  .ex_bubble(ex_bubble), .dm_rd(dm_rd), .dm_wr(dm_wr),
  .irq_ack(irq_ack), .irq_req(irq_req), .br_take(br_take)
);

// File: tb/test_fetch_seq.sv
`timescale 1ns/1ps
module test_fetch_seq;
  typedef struct packed {
    logic        bub;
    logic [13:0] ir;
    logic [12:0] fa;
    logic [12:0] ret;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] fetch_data;
  logic        br_take = 1'b0;
  logic [12:0] br_target = '0;
  logic        irq_req = 1'b0;
  logic [3:0]  q_stb;
  logic [12:0] fetch_addr, ret_addr;
  logic [13:0] ir;
  logic        ex_bubble, dm_rd, dm_wr, irq_ack;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic [12:0] m_fa  = 13'h0000;
  logic        m_bub = 1'b1;
  logic [12:0] m_ret = 13'h0000;
  logic        done = 1'b0;
  localparam logic [12:0] MASK = 13'h07FF;

  always #5 clk = ~clk;

  function automatic logic [13:0] mem(input logic [12:0] a);
    return {1'b0, a} ^ 14'h2A5B;
  endfunction
  assign fetch_data = mem(fetch_addr);

  fetch_seq i_fetch_seq (
    .clk(clk), .rst_n(rst_n), .fetch_data(fetch_data), .br_take(br_take),
    .br_target(br_target), .irq_req(irq_req), .q_stb(q_stb),
    .fetch_addr(fetch_addr), .ir(ir), .ex_bubble(ex_bubble), .dm_rd(dm_rd),
    .dm_wr(dm_wr), .irq_ack(irq_ack), .ret_addr(ret_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input bit br, input logic [12:0] tgt, input bit irq);
    exp_t e;
    logic br_eff;
    do @(negedge clk); while (q_stb != 4'b1000);
    br_take = br; br_target = tgt; irq_req = irq;
    @(negedge clk);
    chk(irq_ack == irq, "R8 irq_ack pulse", irq_ack, irq);
    br_take = 1'b0; irq_req = 1'b0;
    br_eff = br & ~m_bub;
    e.ir = 14'h0000;
    if (irq) begin
      m_ret = br_eff ? (tgt & MASK) : m_fa;
      m_fa = 13'h0004; m_bub = 1'b1;
    end else if (br_eff) begin
      m_fa = tgt & MASK; m_bub = 1'b1;
    end else begin
      e.ir = mem(m_fa);
      m_fa = (m_fa + 1'b1) & MASK; m_bub = 1'b0;
    end
    e.bub = m_bub; e.fa = m_fa; e.ret = m_ret;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    exp_t e;
    logic [3:0] prev = 4'b0001;
    logic cur_bub = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(q_stb == ((prev == 4'b1000) ? 4'b0001 : prev << 1), "R1 phase order", q_stb, prev);
        prev = q_stb;
        if (q_stb == 4'b0010 && q.size() > 0) begin
          e = q.pop_front();
          cur_bub = e.bub;
          chk(ex_bubble == e.bub, "R2/R4/R5 bubble flag", ex_bubble, e.bub);
          chk(ir == e.ir, "R2/R4 instruction word", ir, e.ir);
          chk(fetch_addr == e.fa, "R2/R5/R6/R8 fetch address", fetch_addr, e.fa);
          chk(ret_addr == e.ret, "R8/R9 return address", ret_addr, e.ret);
          chk(dm_rd == !e.bub, "R3 read strobe", dm_rd, !e.bub);
        end
        if (q_stb == 4'b1000)
          chk(dm_wr == !cur_bub, "R3 write strobe", dm_wr, !cur_bub);
        if (q_stb == 4'b0100)
          chk(!dm_rd && !dm_wr, "R3 strobes idle in Q3", {dm_rd, dm_wr}, 0);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(q_stb == 4'b0001, "R1 reset phase", q_stb, 4'b0001);
        chk(fetch_addr == 13'h0000, "R7 reset address", fetch_addr, 0);
        chk(ex_bubble == 1'b1, "R7 reset bubble", ex_bubble, 1);
        chk(irq_ack == 1'b0, "R7 reset ack", irq_ack, 0);
        q.push_back('{bub: 1'b1, ir: 14'h0000, fa: 13'h0000, ret: 13'h0000});
        rst_n = 1'b1;
        repeat (6) run_cycle(1'b0, 13'h0, 1'b0);
        run_cycle(1'b1, 13'h0100, 1'b0);          // R4
        run_cycle(1'b1, 13'h0333, 1'b0);          // R5 ignored in bubble
        repeat (3) run_cycle(1'b0, 13'h0, 1'b0);
        run_cycle(1'b1, 13'h07FE, 1'b0);          // R6 wrap
        repeat (4) run_cycle(1'b0, 13'h0, 1'b0);
        run_cycle(1'b1, 13'h1ABC, 1'b0);          // R6 target mask
        repeat (2) run_cycle(1'b0, 13'h0, 1'b0);
        run_cycle(1'b0, 13'h0, 1'b1);             // R8
        repeat (2) run_cycle(1'b0, 13'h0, 1'b0);
        run_cycle(1'b1, 13'h0055, 1'b1);          // R9
        repeat (2) run_cycle(1'b0, 13'h0, 1'b0);
        run_cycle(1'b1, 13'h0200, 1'b0);
        run_cycle(1'b1, 13'h0600, 1'b1);          // R5/R8 irq during bubble
        repeat (3) run_cycle(1'b0, 13'h0, 1'b0);
        repeat (6) @(negedge clk);
        chk(q.size() == 0, "R2 all cycles observed", q.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule